// File: doc/BRIEF.md
# Lease-Timed L1 Data Cache Controller

This block is the controller of one core's private L1 data cache. It keeps the cache coherent through global time and exchanges no invalidation, recall or acknowledge traffic. Every resident line carries a lease time. A load may use the line only while the lease is still ahead of the global time input. When the lease has run out, the line drops out of use without any message. A load that finds no usable line reads the shared level. The fill that comes back brings the data and a fresh lease.

Stores never allocate a line. Each store goes straight to the shared level. The shared level answers with a write completion time: once global time passes that value, no stale copy of the block remains in any L1. The controller keeps the latest completion time for each warp. A fence from a warp holds that warp until global time has passed its recorded value. Other warps keep running while the fence waits. The controller has one memory operation in flight at a time.

Op encoding on `req_op`: 0 load, 1 store, 2 fence, 3 behaves as a load. The address splits into a set index in the low `$clog2(SETS)` bits and a tag in the bits above it.

Top module: `ltc_l1_ctrl`

## Requirements
- R1: After reset no line is usable, every warp's completion time is zero with no stores recorded, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: A load whose tag matches a resident line with lease strictly greater than `gtime` gets `rsp_valid` with the cached data and its warp in the cycle after acceptance, and no memory request is issued.
- R3: A load to an absent line or to an expired line issues one read request (`mem_req_write`=0, the load address) in the cycle after acceptance. The core response carries `mem_rsp_data` in the cycle after `mem_rsp_valid`. The fill replaces the line's tag, data and lease.
- R4: A store issues one write request with its address and data in the cycle after acceptance, and it never allocates. A store that matches a usable line updates the cached data and leaves the lease unchanged.
- R5: On a store's memory response, the warp's completion time becomes the unsigned maximum of its old value and `mem_rsp_time`. The core response follows one cycle after `mem_rsp_valid`.
- R6: A fence from a warp that has completed no stores, or whose completion time is below `gtime`, responds in the cycle after acceptance.
- R7: Any other fence responds one cycle after the first cycle in which `gtime` exceeds the warp's completion time. Until then that warp's requests see `req_ready`=0, while other warps are still accepted.
- R8: At most one memory operation is in flight. `req_ready` is 0 from the request until its response, and `mem_req_valid` lasts one cycle.
- R9: Lease and completion-time comparisons are unsigned at TW bits. A lease equal to `gtime` counts as expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| gtime | input | TW | global time |
| req_valid | input | 1 | core request present |
| req_ready | output | 1 | core request accepted this cycle if valid |
| req_op | input | 2 | 0 load, 1 store, 2 fence, 3 load |
| req_warp | input | $clog2(WARPS) | issuing warp |
| req_addr | input | AW | word address |
| req_wdata | input | DW | store data |
| rsp_valid | output | 1 | core response pulse |
| rsp_warp | output | $clog2(WARPS) | warp the response belongs to |
| rsp_data | output | DW | load data, zero otherwise |
| mem_req_valid | output | 1 | request to shared level |
| mem_req_write | output | 1 | 1 store, 0 fill read |
| mem_req_addr | output | AW | request address |
| mem_req_wdata | output | DW | store data |
| mem_rsp_valid | input | 1 | shared level answer |
| mem_rsp_data | input | DW | fill data |
| mem_rsp_time | input | TW | fill lease or write completion time |

## Verification
The bench walks every set across the lease boundary. It checks lease-1 (a hit) against lease and the top value 255 (both misses). An off-by-one compare would serve stale data or refill needlessly. A store issued after a larger one returns a smaller completion time. A design that overwrites instead of taking the maximum releases the fence too early. A fence waits while a second warp keeps hitting. A controller that blocks globally, or that lets the fenced warp through, shows up at `req_ready`. Stores to absent and to resident lines are followed by loads. These expose allocation on store and lease refresh on store.

// File: rtl/ltc_pkg.sv
package ltc_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FENCE = 2'd2,
    OP_ALT   = 2'd3
  } ltc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_STORE = 2'd2
  } ltc_state_e;

  // a stamp is still in force when strictly ahead of now (unsigned)
  function automatic logic stamp_ahead(input logic [31:0] stamp, input logic [31:0] now);
    return stamp > now;
  endfunction

  function automatic logic [31:0] stamp_max(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ltc_line_store.sv
module ltc_line_store #(
  parameter int SETS = 4,
  parameter int TAGW = 4,
  parameter int DW   = 8,
  parameter int TW   = 8,
  localparam int IDXW = $clog2(SETS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] rd_idx,
  output logic            rd_present,
  output logic [TAGW-1:0] rd_tag,
  output logic [DW-1:0]   rd_data,
  output logic [TW-1:0]   rd_lease,
  input  logic            fill_en,
  input  logic [IDXW-1:0] fill_idx,
  input  logic [TAGW-1:0] fill_tag,
  input  logic [DW-1:0]   fill_data,
  input  logic [TW-1:0]   fill_lease,
  input  logic            upd_en,
  input  logic [IDXW-1:0] upd_idx,
  input  logic [DW-1:0]   upd_data
);

  logic [SETS-1:0] present_q;
  logic [TAGW-1:0] tag_q   [SETS];
  logic [DW-1:0]   data_q  [SETS];
  logic [TW-1:0]   lease_q [SETS];

  assign rd_present = present_q[rd_idx];
  assign rd_tag     = tag_q[rd_idx];
  assign rd_data    = data_q[rd_idx];
  assign rd_lease   = lease_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) present_q <= '0;
    else if (fill_en) present_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]   <= fill_tag;
      data_q[fill_idx]  <= fill_data;
      lease_q[fill_idx] <= fill_lease;
    end else if (upd_en) begin
      data_q[upd_idx] <= upd_data;
    end
  end

  // a local store never moves the lease
  assert_upd_keeps_lease_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !fill_en) |=> lease_q[$past(upd_idx)] == $past(lease_q[upd_idx]));

endmodule

// File: rtl/ltc_wct_table.sv
module ltc_wct_table
  import ltc_pkg::*;
#(
  parameter int WARPS = 4,
  parameter int TW    = 8,
  localparam int WW = (WARPS > 1) ? $clog2(WARPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] gtime,
  input  logic          upd_en,
  input  logic [WW-1:0] upd_warp,
  input  logic [TW-1:0] upd_time,
  input  logic          fen_en,
  input  logic [WW-1:0] fen_warp,
  output logic          fen_now,
  input  logic [WW-1:0] qry_warp,
  output logic          qry_wait,
  input  logic          fire_take,
  output logic          fire_cand,
  output logic [WW-1:0] fire_warp
);

  logic [TW-1:0]    wct_q [WARPS];
  logic [WARPS-1:0] wrote_q;
  logic [WARPS-1:0] wait_q;
  logic [WARPS-1:0] passed;

  for (genvar g = 0; g < WARPS; g++) begin : g_pass
    assign passed[g] = stamp_ahead(32'(gtime), 32'(wct_q[g]));
  end

  assign fen_now  = !wrote_q[fen_warp] || passed[fen_warp];
  assign qry_wait = wait_q[qry_warp];

  always_comb begin
    fire_cand = 1'b0;
    fire_warp = '0;
    for (int i = WARPS - 1; i >= 0; i--) begin
      if (wait_q[i] && passed[i]) begin
        fire_cand = 1'b1;
        fire_warp = WW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrote_q <= '0;
      wait_q  <= '0;
      for (int i = 0; i < WARPS; i++) wct_q[i] <= '0;
    end else begin
      if (upd_en) begin
        wct_q[upd_warp]   <= TW'(stamp_max(32'(wct_q[upd_warp]), 32'(upd_time)));
        wrote_q[upd_warp] <= 1'b1;
      end
      if (fen_en && !fen_now) wait_q[fen_warp] <= 1'b1;
      if (fire_take) wait_q[fire_warp] <= 1'b0;
    end
  end

  for (genvar g = 0; g < WARPS; g++) begin : g_chk
    assert_wct_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wct_q[g] >= $past(wct_q[g]));
    assert_wait_needs_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q[g] |-> wrote_q[g]);
  end

endmodule

// File: rtl/ltc_l1_ctrl.sv
module ltc_l1_ctrl
  import ltc_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 8,
  parameter int TW    = 8,
  parameter int SETS  = 4,
  parameter int WARPS = 4,
  localparam int IDXW = $clog2(SETS),
  localparam int TAGW = AW - IDXW,
  localparam int WW   = (WARPS > 1) ? $clog2(WARPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] gtime,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [WW-1:0] req_warp,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [WW-1:0] rsp_warp,
  output logic [DW-1:0] rsp_data,
  output logic          mem_req_valid,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  input  logic [TW-1:0] mem_rsp_time
);

  ltc_state_e st_q;
  logic [AW-1:0] pend_addr_q;
  logic [WW-1:0] pend_warp_q;

  logic [IDXW-1:0] req_idx;
  logic [TAGW-1:0] req_tag;
  logic            rd_present;
  logic [TAGW-1:0] rd_tag;
  logic [DW-1:0]   rd_data;
  logic [TW-1:0]   rd_lease;
  logic            line_live;

  logic is_store, is_fence, is_load;
  logic take, hit_evt, miss_evt, store_evt, fence_evt;
  logic mem_take, fill_evt, wct_evt;
  logic fen_now, qry_wait, fire_cand, fence_fire;
  logic [WW-1:0] fire_warp;

  assign req_idx   = req_addr[IDXW-1:0];
  assign req_tag   = req_addr[AW-1:IDXW];
  assign line_live = rd_present && (rd_tag == req_tag) &&
                     stamp_ahead(32'(rd_lease), 32'(gtime));

  assign is_store = (ltc_op_e'(req_op) == OP_STORE);
  assign is_fence = (ltc_op_e'(req_op) == OP_FENCE);
  assign is_load  = !is_store && !is_fence;

  assign mem_take   = (st_q != ST_IDLE) && mem_rsp_valid;
  assign fill_evt   = (st_q == ST_FILL) && mem_rsp_valid;
  assign wct_evt    = (st_q == ST_STORE) && mem_rsp_valid;
  assign fence_fire = fire_cand && !mem_take;

  assign req_ready = (st_q == ST_IDLE) && !fence_fire && !qry_wait;
  assign take      = req_valid && req_ready;
  assign hit_evt   = take && is_load && line_live;
  assign miss_evt  = take && is_load && !line_live;
  assign store_evt = take && is_store;
  assign fence_evt = take && is_fence;

  ltc_line_store #(.SETS(SETS), .TAGW(TAGW), .DW(DW), .TW(TW)) lines_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (req_idx),
    .rd_present (rd_present),
    .rd_tag     (rd_tag),
    .rd_data    (rd_data),
    .rd_lease   (rd_lease),
    .fill_en    (fill_evt),
    .fill_idx   (pend_addr_q[IDXW-1:0]),
    .fill_tag   (pend_addr_q[AW-1:IDXW]),
    .fill_data  (mem_rsp_data),
    .fill_lease (mem_rsp_time),
    .upd_en     (store_evt && line_live),
    .upd_idx    (req_idx),
    .upd_data   (req_wdata)
  );

  ltc_wct_table #(.WARPS(WARPS), .TW(TW)) wct_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .gtime     (gtime),
    .upd_en    (wct_evt),
    .upd_warp  (pend_warp_q),
    .upd_time  (mem_rsp_time),
    .fen_en    (fence_evt),
    .fen_warp  (req_warp),
    .fen_now   (fen_now),
    .qry_warp  (req_warp),
    .qry_wait  (qry_wait),
    .fire_take (fence_fire),
    .fire_cand (fire_cand),
    .fire_warp (fire_warp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      pend_addr_q   <= '0;
      pend_warp_q   <= '0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      rsp_valid     <= 1'b0;
      rsp_warp      <= '0;
      rsp_data      <= '0;
    end else begin
      mem_req_valid <= miss_evt || store_evt;
      if (miss_evt || store_evt) begin
        mem_req_write <= store_evt;
        mem_req_addr  <= req_addr;
        mem_req_wdata <= req_wdata;
        pend_addr_q   <= req_addr;
        pend_warp_q   <= req_warp;
        st_q          <= store_evt ? ST_STORE : ST_FILL;
      end else if (mem_take) begin
        st_q <= ST_IDLE;
      end

      rsp_valid <= hit_evt || (fence_evt && fen_now) || mem_take || fence_fire;
      rsp_data  <= hit_evt ? rd_data : (fill_evt ? mem_rsp_data : '0);
      if (mem_take)        rsp_warp <= pend_warp_q;
      else if (fence_fire) rsp_warp <= fire_warp;
      else                 rsp_warp <= req_warp;
    end
  end

  assert_one_flight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
  assert_hit_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (rsp_valid && !mem_req_valid));
  assert_fill_returns_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> (rsp_valid && rsp_data == $past(mem_rsp_data)));
  assert_fence_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fence_fire |=> (rsp_valid && rsp_warp == $past(fire_warp)));

endmodule

// File: tb/ltc_l1_ctrl_tb.sv
module ltc_l1_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] gtime = '0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_op = '0;
  logic [1:0] req_warp = '0;
  logic [5:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic [1:0] rsp_warp;
  logic [7:0] rsp_data;
  logic       mem_req_valid, mem_req_write;
  logic [5:0] mem_req_addr;
  logic [7:0] mem_req_wdata;
  logic       mem_rsp_valid = 1'b0;
  logic [7:0] mem_rsp_data = '0;
  logic [7:0] mem_rsp_time = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ltc_l1_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .gtime(gtime),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_warp(req_warp), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_warp(rsp_warp), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_time(mem_rsp_time)
  );

  task automatic chk(input string rq, input logic ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    gtime = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive one request at a negedge; return at the following negedge
  task automatic send(input string rq, input logic [1:0] op, input logic [1:0] w,
                      input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_warp = w; req_addr = a; req_wdata = d;
    #1 chk(rq, req_ready == 1'b1, req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic probe_ready(input string rq, input logic [1:0] w, input logic exp);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_warp = w;
    #1 chk(rq, req_ready == exp, req_ready, exp);
    #1 req_valid = 1'b0;
  endtask

  task automatic reply(input string rq, input logic [7:0] d, input logic [7:0] t,
                       input logic [1:0] w, input logic [7:0] exp_data);
    mem_rsp_valid = 1'b1; mem_rsp_data = d; mem_rsp_time = t;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk(rq, rsp_valid && rsp_warp == w && rsp_data == exp_data, rsp_data, exp_data);
    chk(rq, !mem_req_valid, mem_req_valid, 0);
  endtask

  task automatic load_hit(input string rq, input logic [1:0] w, input logic [5:0] a,
                          input logic [7:0] exp);
    send(rq, 2'd0, w, a, 8'h00);
    chk(rq, rsp_valid && rsp_warp == w && rsp_data == exp, rsp_data, exp);
    chk(rq, !mem_req_valid, mem_req_valid, 0);
  endtask

  task automatic load_miss(input string rq, input logic [1:0] w, input logic [5:0] a,
                           input logic [7:0] d, input logic [7:0] lease);
    send(rq, 2'd0, w, a, 8'h00);
    chk(rq, mem_req_valid && !mem_req_write && mem_req_addr == a, mem_req_addr, a);
    chk(rq, !rsp_valid, rsp_valid, 0);
    chk("R8 busy", req_ready == 1'b0, req_ready, 0);
    reply(rq, d, lease, w, d);
  endtask

  task automatic store_op(input string rq, input logic [1:0] w, input logic [5:0] a,
                          input logic [7:0] d, input logic [7:0] wct);
    send(rq, 2'd1, w, a, d);
    chk(rq, mem_req_valid && mem_req_write && mem_req_addr == a && mem_req_wdata == d,
        mem_req_wdata, d);
    chk("R8 busy", req_ready == 1'b0, req_ready, 0);
    reply(rq, 8'h00, wct, w, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    @(negedge clk);
    chk("R1 ready", req_ready == 1'b1, req_ready, 1);
    chk("R1 rsp", rsp_valid == 1'b0, rsp_valid, 0);
    chk("R1 memreq", mem_req_valid == 1'b0, mem_req_valid, 0);

    // R2 R3 R9: every set across the lease boundary
    for (int s = 0; s < 4; s++) begin
      logic [5:0] a;
      a = {4'(s + 3), 2'(s)};
      gtime = 8'd10;
      load_miss("R3 first fill", 2'(s), a, 8'hA0 + 8'(s), 8'd40 + 8'(s));
      gtime = 8'd39 + 8'(s);
      load_hit("R2 live hit", 2'(s), a, 8'hA0 + 8'(s));
      gtime = 8'd40 + 8'(s);
      load_miss("R9 lease equal expired", 2'(s), a, 8'hC0 + 8'(s), 8'd255);
      gtime = 8'd254;
      load_hit("R3 refilled lease", 2'(s), a, 8'hC0 + 8'(s));
      gtime = 8'd255;
      load_miss("R9 top value expired", 2'(s), a, 8'hD0 + 8'(s), 8'd255);
    end

    // R1: reset drops the lines
    do_reset();
    gtime = 8'd5;
    load_miss("R1 lines cleared", 2'd0, {4'd3, 2'd0}, 8'h11, 8'd60);

    // R4: no allocate on store, local update keeps lease
    load_miss("R4 setup", 2'd0, 6'b0010_01, 8'd11, 8'd60);
    store_op("R4 store absent", 2'd0, 6'b0101_01, 8'd22, 8'd20);
    gtime = 8'd6;
    load_hit("R4 no allocate", 2'd0, 6'b0010_01, 8'd11);
    load_miss("R4 store line absent", 2'd0, 6'b0101_01, 8'd33, 8'd70);
    store_op("R4 store live", 2'd0, 6'b0101_01, 8'd44, 8'd25);
    load_hit("R4 local update", 2'd0, 6'b0101_01, 8'd44);
    gtime = 8'd69;
    load_hit("R4 lease kept", 2'd0, 6'b0101_01, 8'd44);
    gtime = 8'd70;
    load_miss("R4 lease not extended", 2'd0, 6'b0101_01, 8'd55, 8'd200);

    // R5 R7: maximum kept, fence waits, other warps flow
    store_op("R5 store big", 2'd1, 6'd0, 8'd1, 8'd40);
    store_op("R5 store small", 2'd1, 6'd1, 8'd2, 8'd30);
    gtime = 8'd35;
    send("R7 fence accept", 2'd2, 2'd1, 6'd0, 8'd0);
    chk("R5 fence waits on max", !rsp_valid, rsp_valid, 0);
    probe_ready("R7 fenced warp blocked", 2'd1, 1'b0);
    load_hit("R7 other warp runs", 2'd0, 6'b0101_01, 8'd55);
    gtime = 8'd40;
    repeat (2) begin
      @(negedge clk);
      chk("R7 equal still waits", !rsp_valid, rsp_valid, 0);
    end
    probe_ready("R7 still blocked", 2'd1, 1'b0);
    @(negedge clk);
    gtime = 8'd41;
    @(negedge clk);
    chk("R7 release", rsp_valid && rsp_warp == 2'd1, rsp_warp, 1);
    @(negedge clk);
    chk("R7 single pulse", !rsp_valid, rsp_valid, 0);
    probe_ready("R7 unblocked", 2'd1, 1'b1);

    // R6: immediate fences
    send("R6 fence no stores", 2'd2, 2'd2, 6'd0, 8'd0);
    chk("R6 no stores", rsp_valid && rsp_warp == 2'd2, rsp_warp, 2);
    send("R6 fence passed", 2'd2, 2'd1, 6'd0, 8'd0);
    chk("R6 passed", rsp_valid && rsp_warp == 2'd1, rsp_warp, 1);
    send("R6 fence warp0", 2'd2, 2'd0, 6'd0, 8'd0);
    chk("R6 warp0 passed", rsp_valid && rsp_warp == 2'd0, rsp_warp, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule